// File: doc/BRIEF.md
# Ingress Timestamp and Idle-Cell Generator

This block sits at one input of a cell switch and turns every cell slot into exactly one outgoing cell. A free-running cell-time counter advances once per slot pulse. On each slot pulse the block looks at the input cell interface. If a cell is offered, the block forwards it as a REAL cell with the current count attached as its timestamp. If no cell is offered, the block builds a DUMMY cell that carries only the timestamp. Downstream timestamp comparators can then make progress even when the input is silent.

The output follows each slot pulse by one clock and is valid for one clock only. The timestamp is a W-bit count that wraps modulo 2^W. Downstream logic compares timestamps with serial-number arithmetic.

Control is a three-state machine:
- `ST_IDLE`: no output this clock.
- `ST_REAL`: a real cell is on the output.
- `ST_DUMMY`: an idle cell is on the output.

The transitions are the same from every state:
- `T_ARRIVE`: slot pulse with input valid, go to `ST_REAL`.
- `T_EMPTY`: slot pulse without input valid, go to `ST_DUMMY`.
- `T_QUIET`: no slot pulse, go to `ST_IDLE`.

Top module: `ingress_stamper`

## Requirements
- R1: After reset `out_valid` is 0, and the first slot after reset carries timestamp 0.
- R2: Each slot pulse produces exactly one output with `out_valid`=1 on the following clock. With no slot pulse, the following clock has `out_valid`=0.
- R3: The timestamp of the k-th slot after reset (counting from 0) equals k modulo 2^TS_W. Successive outputs differ by exactly one.
- R4: A slot with `in_valid`=1 yields `out_real`=1 and copies `in_dest` and `in_handle` from the slot-pulse clock.
- R5: A slot with `in_valid`=0 yields a dummy cell: `out_real`=0, `out_dest`=0 and `out_handle`=0, with a normal timestamp.
- R6: `in_valid`, `in_dest` and `in_handle` have no effect when `slot_pulse` is 0. No output appears, and the count does not move.
- R7: After the slot stamped 2^TS_W-1, the next slot is stamped 0.
- R8: Slot pulses on consecutive clocks produce outputs on consecutive clocks, each correctly typed and stamped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_pulse | input | 1 | One-clock marker of a cell slot |
| in_valid | input | 1 | A cell is offered in this slot |
| in_dest | input | DEST_W | Destination of the offered cell |
| in_handle | input | HANDLE_W | Payload handle of the offered cell |
| out_valid | output | 1 | Output cell present (one clock per slot) |
| out_real | output | 1 | Cell type: 1 = REAL, 0 = DUMMY |
| out_ts | output | TS_W | Timestamp of the slot |
| out_dest | output | DEST_W | Destination (0 for DUMMY) |
| out_handle | output | HANDLE_W | Payload handle (0 for DUMMY) |

## Verification
A wrong counter value shows up in the `out_ts` of the very next slot. From then on every following stamp is off, so one slot is enough to see it.

A wrong state register shows up on the clock after the slot pulse, as one of these:
- a missing or extra `out_valid`;
- a REAL/DUMMY type swapped against `in_valid`.

A wrong payload latch shows up as leaked destination or handle bits on a dummy cell, or as stale data on a real one. It too is visible one clock after the slot.

The bench uses a 4-bit count, so several full wraps fit in one run. It checks every slot against an arithmetic model.

// File: rtl/ingress_stamper_pkg.sv
package ingress_stamper_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_REAL  = 2'd1,
        ST_DUMMY = 2'd2
    } slot_state_t;
endpackage

// File: rtl/stamp_counter.sv
module stamp_counter #(
    parameter int TS_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            advance,
    output logic [TS_W-1:0] count
);
    logic [TS_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (advance) begin
            count_q <= count_q + 1'b1;
        end
    end

    assign count = count_q;
endmodule

// File: rtl/slot_fsm.sv
module slot_fsm
    import ingress_stamper_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic slot_pulse,
    input  logic in_valid,
    output logic emit,
    output logic emit_real
);
    slot_state_t state_q, state_d;

    always_comb begin
        unique case ({slot_pulse, in_valid})
            2'b11:   state_d = ST_REAL;
            2'b10:   state_d = ST_DUMMY;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_REAL: begin
                emit      = 1'b1;
                emit_real = 1'b1;
            end
            ST_DUMMY: begin
                emit      = 1'b1;
                emit_real = 1'b0;
            end
            default: begin
                emit      = 1'b0;
                emit_real = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/cell_former.sv
module cell_former #(
    parameter int TS_W     = 8,
    parameter int DEST_W   = 4,
    parameter int HANDLE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                capture,
    input  logic [TS_W-1:0]     ts_in,
    input  logic [DEST_W-1:0]   dest_in,
    input  logic [HANDLE_W-1:0] handle_in,
    input  logic                emit_real,
    output logic [TS_W-1:0]     ts_out,
    output logic [DEST_W-1:0]   dest_out,
    output logic [HANDLE_W-1:0] handle_out
);
    logic [TS_W-1:0]     ts_q;
    logic [DEST_W-1:0]   dest_q;
    logic [HANDLE_W-1:0] handle_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ts_q     <= '0;
            dest_q   <= '0;
            handle_q <= '0;
        end else if (capture) begin
            ts_q     <= ts_in;
            dest_q   <= dest_in;
            handle_q <= handle_in;
        end
    end

    // Idle cells carry only the stamp; identity fields are forced to zero.
    assign ts_out     = ts_q;
    assign dest_out   = emit_real ? dest_q : '0;
    assign handle_out = emit_real ? handle_q : '0;
endmodule

// File: rtl/ingress_stamper.sv
module ingress_stamper #(
    parameter int TS_W     = 8,
    parameter int DEST_W   = 4,
    parameter int HANDLE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                slot_pulse,
    input  logic                in_valid,
    input  logic [DEST_W-1:0]   in_dest,
    input  logic [HANDLE_W-1:0] in_handle,
    output logic                out_valid,
    output logic                out_real,
    output logic [TS_W-1:0]     out_ts,
    output logic [DEST_W-1:0]   out_dest,
    output logic [HANDLE_W-1:0] out_handle
);
    logic [TS_W-1:0] now_ts;
    logic            emit;
    logic            emit_real;

    stamp_counter #(.TS_W(TS_W)) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (slot_pulse),
        .count   (now_ts)
    );

    slot_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .slot_pulse (slot_pulse),
        .in_valid   (in_valid),
        .emit       (emit),
        .emit_real  (emit_real)
    );

    cell_former #(
        .TS_W     (TS_W),
        .DEST_W   (DEST_W),
        .HANDLE_W (HANDLE_W)
    ) u_former (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture    (slot_pulse),
        .ts_in      (now_ts),
        .dest_in    (in_dest),
        .handle_in  (in_handle),
        .emit_real  (emit_real),
        .ts_out     (out_ts),
        .dest_out   (out_dest),
        .handle_out (out_handle)
    );

    assign out_valid = emit;
    assign out_real  = emit_real;
endmodule

// File: rtl/ingress_stamper_checker.sv
module ingress_stamper_checker #(
    parameter int TS_W     = 8,
    parameter int DEST_W   = 4,
    parameter int HANDLE_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                slot_pulse,
    input logic                in_valid,
    input logic [DEST_W-1:0]   in_dest,
    input logic [HANDLE_W-1:0] in_handle,
    input logic                out_valid,
    input logic                out_real,
    input logic [TS_W-1:0]     out_ts,
    input logic [DEST_W-1:0]   out_dest,
    input logic [HANDLE_W-1:0] out_handle
);
    logic            seen_q;
    logic [TS_W-1:0] last_q;
    logic [TS_W-1:0] next_expected;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            last_q <= '0;
        end else if (out_valid) begin
            seen_q <= 1'b1;
            last_q <= out_ts;
        end
    end

    assign next_expected = last_q + 1'b1;

    p_first_ts_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !seen_q) |-> (out_ts == '0));

    p_slot_emits_r2: assert property (@(posedge clk) disable iff (!rst_n)
        slot_pulse |=> out_valid);

    p_quiet_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_pulse |=> !out_valid);

    p_ts_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && seen_q) |-> (out_ts == next_expected));

    p_real_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_pulse && in_valid) |=>
            (out_real && out_dest == $past(in_dest) && out_handle == $past(in_handle)));

    p_dummy_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_pulse && !in_valid) |=> (!out_real && out_dest == '0 && out_handle == '0));
endmodule

bind ingress_stamper ingress_stamper_checker #(
    .TS_W     (TS_W),
    .DEST_W   (DEST_W),
    .HANDLE_W (HANDLE_W)
) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .slot_pulse (slot_pulse),
    .in_valid   (in_valid),
    .in_dest    (in_dest),
    .in_handle  (in_handle),
    .out_valid  (out_valid),
    .out_real   (out_real),
    .out_ts     (out_ts),
    .out_dest   (out_dest),
    .out_handle (out_handle)
);

// File: tb/ingress_stamper_bench.sv
`timescale 1ns/1ps
module ingress_stamper_bench;
    localparam int TS_W     = 4;
    localparam int DEST_W   = 3;
    localparam int HANDLE_W = 6;
    localparam int TS_MOD   = 1 << TS_W;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                slot_pulse = 1'b0;
    logic                in_valid = 1'b0;
    logic [DEST_W-1:0]   in_dest = '0;
    logic [HANDLE_W-1:0] in_handle = '0;
    logic                out_valid;
    logic                out_real;
    logic [TS_W-1:0]     out_ts;
    logic [DEST_W-1:0]   out_dest;
    logic [HANDLE_W-1:0] out_handle;

    int checks = 0;
    int errors = 0;
    int exp_ts = 0;
    int slots_done = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    ingress_stamper #(
        .TS_W     (TS_W),
        .DEST_W   (DEST_W),
        .HANDLE_W (HANDLE_W)
    ) u_ingress_stamper (
        .clk        (clk),
        .rst_n      (rst_n),
        .slot_pulse (slot_pulse),
        .in_valid   (in_valid),
        .in_dest    (in_dest),
        .in_handle  (in_handle),
        .out_valid  (out_valid),
        .out_real   (out_real),
        .out_ts     (out_ts),
        .out_dest   (out_dest),
        .out_handle (out_handle)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive one clock of stimulus; check the output on the clock that follows.
    task automatic step(input logic p, input logic v, input int d, input int h, input string vtag);
        slot_pulse = p;
        in_valid   = v;
        in_dest    = DEST_W'(d);
        in_handle  = HANDLE_W'(h);
        @(posedge clk);
        @(negedge clk);
        if (p) begin
            chk(vtag, int'(out_valid), 1);
            chk((slots_done > 0 && exp_ts == 0) ? "R7" : "R3", int'(out_ts), exp_ts);
            if (v) begin
                chk("R4", int'(out_real), 1);
                chk("R4", int'(out_dest), d % (1 << DEST_W));
                chk("R4", int'(out_handle), h % (1 << HANDLE_W));
            end else begin
                chk("R5", int'(out_real), 0);
                chk("R5", int'(out_dest), 0);
                chk("R5", int'(out_handle), 0);
            end
            exp_ts = (exp_ts + 1) % TS_MOD;
            slots_done++;
        end else begin
            chk(v ? "R6" : "R2", int'(out_valid), 0);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", int'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", int'(out_valid), 0);

        // First slot after reset is stamped zero (R1).
        step(1'b1, 1'b1, 5, 17, "R1");

        // Back-to-back slots, mixed real and idle (R8), beyond two wraps (R7).
        for (int i = 0; i < 40; i++) begin
            step(1'b1, (i % 3) != 0, i, i * 5, "R8");
        end

        // Spaced slots with traffic offered between pulses (R2, R6).
        for (int i = 0; i < 24; i++) begin
            for (int g = 0; g < (i % 4); g++) begin
                step(1'b0, 1'b1, 7 - g, 63 - i, "R6");
            end
            step(1'b1, (i % 2) == 0, i + 3, i * 11, "R2");
        end

        // Full sweep of destinations and handle bit patterns, both cell types.
        for (int d = 0; d < (1 << DEST_W); d++) begin
            for (int t = 0; t < 2; t++) begin
                step(1'b1, t == 1, d, (d * 9 + t * 37) % 64, "R2");
                step(1'b0, 1'b0, 0, 0, "R2");
            end
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule